// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

This block is a watchdog for a small processor. A prescaled counter advances on watchdog clock ticks. Unless the processor restarts the counter in time, it reaches a programmable limit. One 8-bit register holds the whole configuration and status. What happens on a timeout depends on two enable bits and a fuse input. The block can do nothing, raise an interrupt, pulse a system reset, or raise an interrupt first and escalate to a reset if the interrupt is not serviced.

Two things are hard to turn off by accident: the reset enable and the timeout period. Clearing the reset-enable bit or altering the prescaler is accepted only within a short change window. Software opens that window by writing the change-enable bit, and hardware closes it again after four clock cycles. A reset-flag input from the reset controller holds the reset enable on for as long as the flag stays set. An always-on fuse input forces system reset behaviour whatever the register holds.

Top module: `wdt_guard`

## Requirements
- R1: After reset every register bit reads 0, except the reset-enable bit (bit 3), which reads the level of `rst_flag_i`.
- R2: The register layout is: bit 7 timeout flag, bit 6 interrupt enable, bit 5 prescaler bit 3, bit 4 change window, bit 3 reset enable, bits 2..0 prescaler bits 2..0.
- R3: With interrupt enable set and reset enable clear, the flag sets after 2^(BASE_EXP+N) ticks counted from the last counter restart, where N is the prescaler code. No system reset is issued in this mode.
- R4: `irq_o` is high exactly when the flag, the interrupt enable and `gie_i` are all set.
- R5: The flag is cleared by `vec_ack_i` or by writing a 1 to bit 7. Writing 0 to bit 7 leaves it unchanged.
- R6: With reset enable set and interrupt enable clear, a timeout gives a one-cycle `sys_rst_o` pulse in the cycle after the timeout, and the flag stays clear.
- R7: With both enables set, the first timeout sets the flag. If a later timeout finds the flag still set, it pulses `sys_rst_o`. `vec_ack_i` clears both the flag and the interrupt enable, which leaves reset mode.
- R8: Writing 1 to bit 4 opens the change window for exactly four cycles. Outside the window, writes that clear reset enable or alter the prescaler are ignored.
- R9: Writes that set reset enable or set interrupt enable are accepted at any time.
- R10: While `rst_flag_i` is high, reset enable reads 1 and cannot be cleared. After the flag drops, reset enable stays set until it is cleared through the window.
- R11: With `always_on_i` high, a timeout pulses `sys_rst_o` and never sets the flag, whatever the enable bits hold.
- R12: With both enables clear and the fuse off, the counter is held and no timeout action occurs.
- R13: `kick_i` restarts the counter, and so does an accepted prescaler change.
- R14: Prescaler codes 10 to 15 read back as written but give the same period as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Watchdog clock tick enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| kick_i | input | 1 | Counter restart strobe |
| gie_i | input | 1 | Global interrupt enable |
| vec_ack_i | input | 1 | Interrupt vector taken |
| always_on_i | input | 1 | Fuse forcing system reset mode |
| rst_flag_i | input | 1 | Watchdog reset flag from the reset controller |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Several properties are checked on every cycle. The prescaler never moves without an open window, and reset enable never falls except through a windowed write while the reset flag is low. An acknowledge always clears the flag, the flag rises only on a timeout, and the reset output never lasts two cycles. The fuse always turns a timeout into a reset, and a restart is never directly followed by a timeout. Only the bench scenarios can show the things that depend on counting. These are the exact period for each prescaler code, the exact four-cycle length of the window, the escalation order in combined mode, and the effect of a restart on when the next timeout falls.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned PS_W     = 4;
  localparam int unsigned PS_MAX   = 9;
  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_PS3  = 5;
  localparam int unsigned BIT_CE   = 4;
  localparam int unsigned BIT_RE   = 3;

  typedef enum logic [1:0] {
    MODE_STOP,
    MODE_IRQ,
    MODE_RST,
    MODE_IRQ_RST
  } wdt_mode_e;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
#(
  parameter int unsigned CE_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rst_flag_i,
  input  logic             flag_set_i,
  input  logic             vec_ack_i,
  input  logic             combo_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             ie_o,
  output logic             re_o,
  output logic             flag_o,
  output logic [PS_W-1:0]  ps_o,
  output logic             ps_chg_o
);
  localparam int unsigned CE_W = $clog2(CE_CYCLES + 1);

  logic [CE_W-1:0] ce_cnt_q;
  logic            ce_open;
  logic            re_q, re_d;
  logic            ie_q, ie_d;
  logic            flag_q, flag_d;
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] wr_ps;
  logic            re_eff;

  assign ce_open  = (ce_cnt_q != '0);
  assign wr_ps    = {wdata_i[BIT_PS3], wdata_i[2:0]};
  assign ps_chg_o = we_i && ce_open && (wr_ps != ps_q);
  assign re_eff   = re_q | rst_flag_i;

  always_comb begin
    re_d = re_eff;
    if (we_i) begin
      if (wdata_i[BIT_RE])                re_d = 1'b1;
      else if (ce_open && !rst_flag_i)    re_d = 1'b0;
    end
  end

  always_comb begin
    ie_d = ie_q;
    if (we_i)                 ie_d = wdata_i[BIT_IE];
    if (vec_ack_i && combo_i) ie_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (vec_ack_i || (we_i && wdata_i[BIT_FLAG])) flag_d = 1'b0;
    if (flag_set_i)                                flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_cnt_q <= '0;
      re_q     <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      ps_q     <= '0;
    end else begin
      if (we_i && wdata_i[BIT_CE]) ce_cnt_q <= CE_W'(CE_CYCLES);
      else if (ce_open)            ce_cnt_q <= ce_cnt_q - 1'b1;
      re_q   <= re_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      if (ps_chg_o) ps_q <= wr_ps;
    end
  end

  assign rdata_o = {flag_q, ie_q, ps_q[3], ce_open, re_eff, ps_q[2:0]};
  assign ie_o    = ie_q;
  assign re_o    = re_eff;
  assign flag_o  = flag_q;
  assign ps_o    = ps_q;

  // R8
  ps_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ps_q) |-> $past(ce_open));

  // R10
  re_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(re_q) |-> $past(ce_open && !rst_flag_i && we_i));

  // R5
  flag_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && !flag_set_i) |=> !flag_q);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            timeout_o
);
  localparam int unsigned CNT_W = BASE_EXP + PS_MAX + 1;
  localparam int unsigned SH_W  = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [PS_W-1:0]  ps_eff;
  logic [SH_W-1:0]  shamt;

  // reserved codes fall back to the shortest period
  assign ps_eff    = (ps_i > PS_W'(PS_MAX)) ? '0 : ps_i;
  assign shamt     = SH_W'(BASE_EXP) + SH_W'(ps_eff);
  assign last      = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign timeout_o = run_i && tick_i && !restart_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (restart_i || !run_i)   cnt_q <= '0;
    else if (tick_i)                cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  // R13
  restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !timeout_o);
endmodule

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic always_on_i,
  input  logic ie_i,
  input  logic re_i,
  input  logic flag_i,
  input  logic timeout_i,
  output logic run_o,
  output logic combo_o,
  output logic flag_set_o,
  output logic sys_rst_o
);
  wdt_mode_e mode;
  logic      rst_fire;
  logic      sys_rst_q;

  always_comb begin
    if (always_on_i) mode = MODE_RST;
    else begin
      unique case ({re_i, ie_i})
        2'b00:   mode = MODE_STOP;
        2'b01:   mode = MODE_IRQ;
        2'b10:   mode = MODE_RST;
        default: mode = MODE_IRQ_RST;
      endcase
    end
  end

  assign run_o      = (mode != MODE_STOP);
  assign combo_o    = (mode == MODE_IRQ_RST);
  assign flag_set_o = timeout_i && ((mode == MODE_IRQ) || (combo_o && !flag_i));
  // escalate when the earlier interrupt went unserviced
  assign rst_fire   = timeout_i && ((mode == MODE_RST) || (combo_o && flag_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_rst_q <= 1'b0;
    else         sys_rst_q <= rst_fire;
  end

  assign sys_rst_o = sys_rst_q;

  // R6
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_q |=> !sys_rst_q);

  // R11
  fuse_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (always_on_i && timeout_i) |=> sys_rst_o);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP  = 11,
  parameter int unsigned CE_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       kick_i,
  input  logic       gie_i,
  input  logic       vec_ack_i,
  input  logic       always_on_i,
  input  logic       rst_flag_i,
  output logic       irq_o,
  output logic       sys_rst_o
);
  logic            ie, re, flag, ps_chg;
  logic [PS_W-1:0] ps;
  logic            run, combo, flag_set, timeout;

  wdt_cfg_reg #(.CE_CYCLES(CE_CYCLES)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .rst_flag_i (rst_flag_i),
    .flag_set_i (flag_set),
    .vec_ack_i  (vec_ack_i),
    .combo_i    (combo),
    .rdata_o    (reg_rdata_o),
    .ie_o       (ie),
    .re_o       (re),
    .flag_o     (flag),
    .ps_o       (ps),
    .ps_chg_o   (ps_chg)
  );

  wdt_timer #(.BASE_EXP(BASE_EXP)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (run),
    .restart_i (kick_i | ps_chg),
    .ps_i      (ps),
    .timeout_o (timeout)
  );

  wdt_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .always_on_i (always_on_i),
    .ie_i        (ie),
    .re_i        (re),
    .flag_i      (flag),
    .timeout_i   (timeout),
    .run_o       (run),
    .combo_o     (combo),
    .flag_set_o  (flag_set),
    .sys_rst_o   (sys_rst_o)
  );

  assign irq_o = flag && ie && gie_i;

  // R3
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(timeout));
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       kick_i = 1'b0;
  logic       gie_i = 1'b1;
  logic       vec_ack_i = 1'b0;
  logic       always_on_i = 1'b0;
  logic       rst_flag_i = 1'b0;
  logic       irq_o;
  logic       sys_rst_o;

  always #2 clk_i = ~clk_i;

  wdt_guard #(.BASE_EXP(4), .CE_CYCLES(4)) uut (.*);

  typedef struct {
    int         cyc;
    int         sel;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  exp_t item;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compares queued expectations 1 ns after the falling edge
  always @(negedge clk_i) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      logic [7:0] act;
      string      nm;
      item = q.pop_front();
      case (item.sel)
        0:       begin act = reg_rdata_o;      nm = "rdata";   end
        1:       begin act = {7'd0, irq_o};     nm = "irq";     end
        default: begin act = {7'd0, sys_rst_o}; nm = "sys_rst"; end
      endcase
      checks++;
      if (act !== item.val) begin
        failures++;
        $display("FAIL %s: %s actual=%02h expected=%02h (cycle %0d)",
                 item.req, nm, act, item.val, cyc);
      end
    end
  end

  task automatic expect_rd(logic [7:0] v, string req);
    q.push_back('{cyc, 0, v, req});
  endtask
  task automatic expect_irq(logic v, string req);
    q.push_back('{cyc, 1, {7'd0, v}, req});
  endtask
  task automatic expect_rst(logic v, string req);
    q.push_back('{cyc, 2, {7'd0, v}, req});
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask
  task automatic wr(logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask
  task automatic kick();
    kick_i = 1'b1;
    @(negedge clk_i);
    kick_i = 1'b0;
  endtask
  task automatic ack();
    vec_ack_i = 1'b1;
    @(negedge clk_i);
    vec_ack_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    expect_rd(8'h00, "R1"); expect_irq(1'b0, "R1"); expect_rst(1'b0, "R1");
    idle(1);
    rst_flag_i = 1'b1;
    expect_rd(8'h08, "R1");
    idle(1);
    // R10 clear attempt while flag held
    wr(8'h18); wr(8'h00);
    expect_rd(8'h18, "R10");
    rst_flag_i = 1'b0;
    idle(1);
    expect_rd(8'h18, "R10");
    // R8 windowed clear and window length
    wr(8'h18); wr(8'h00);
    expect_rd(8'h10, "R8");
    idle(2); expect_rd(8'h10, "R8");
    idle(1); expect_rd(8'h00, "R8");
    wr(8'h07); expect_rd(8'h00, "R8");
    // interrupt mode
    wr(8'h40); expect_rd(8'h40, "R9");
    idle(15); expect_rd(8'h40, "R3"); expect_irq(1'b0, "R3");
    idle(1);  expect_rd(8'hC0, "R3"); expect_irq(1'b1, "R4"); expect_rst(1'b0, "R3");
    idle(1);
    gie_i = 1'b0; expect_irq(1'b0, "R4");
    wr(8'hC0);
    gie_i = 1'b1; expect_irq(1'b0, "R5"); expect_rd(8'h40, "R5");
    idle(13); expect_rd(8'h40, "R3");
    idle(1);  expect_rd(8'hC0, "R3");
    ack(); expect_rd(8'h40, "R5"); expect_irq(1'b0, "R5");
    kick();
    idle(15); expect_rd(8'h40, "R13");
    idle(1);  expect_rd(8'hC0, "R13");
    wr(8'hC0);
    // prescaler change inside window
    wr(8'h50); wr(8'h41);
    expect_rd(8'h51, "R2");
    idle(31); expect_rd(8'h41, "R13");
    idle(1);  expect_rd(8'hC1, "R13");
    // reserved code 12
    wr(8'hD1); wr(8'h64);
    expect_rd(8'h74, "R2");
    idle(15); expect_rd(8'h64, "R14");
    idle(1);  expect_rd(8'hE4, "R14");
    // back to stopped
    wr(8'hF4); wr(8'h00);
    expect_rd(8'h10, "R12");
    idle(40);
    expect_rd(8'h00, "R12"); expect_irq(1'b0, "R12"); expect_rst(1'b0, "R12");
    // reset mode
    wr(8'h08); expect_rd(8'h08, "R9");
    idle(15); expect_rst(1'b0, "R6");
    idle(1);  expect_rst(1'b1, "R6"); expect_rd(8'h08, "R6");
    idle(1);  expect_rst(1'b0, "R6");
    // combined mode
    wr(8'h48); kick();
    idle(15); expect_rd(8'h48, "R7");
    idle(1);  expect_rd(8'hC8, "R7"); expect_irq(1'b1, "R7"); expect_rst(1'b0, "R7");
    idle(15); expect_rst(1'b0, "R7");
    idle(1);  expect_rst(1'b1, "R7"); expect_rd(8'hC8, "R7");
    ack(); expect_rd(8'h08, "R7");
    idle(14); expect_rst(1'b0, "R7");
    idle(1);  expect_rst(1'b1, "R7"); expect_rd(8'h08, "R7");
    // always-on fuse
    wr(8'h18); wr(8'h00); wr(8'h40);
    always_on_i = 1'b1;
    kick();
    idle(15); expect_rst(1'b0, "R11");
    idle(1);  expect_rst(1'b1, "R11"); expect_rd(8'h40, "R11");
    idle(3);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL queue: %0d expectations left unchecked", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule